// File: doc/BRIEF.md
# Key Range Search Sequencer

This block drives one search lane of a brute-force key search. A host writes a wide starting key. The block then offers candidate keys, one per accepted handshake, to an external test datapath. The high part of the key stays frozen. Only a low-order counter of `LOW_W` bits advances, from the loaded low value up to all ones. The datapath returns one result per accepted key, in issue order and after any latency. The block keeps a small record of the low values that are still in flight, so that a result can always be matched to the key that produced it.

A positive result pauses the lane and exposes the key that produced it. When the host resumes, the lane continues with the key that follows the hit. When the whole low range has been offered and every result has come back without a hit, the lane halts with a need-new-key status and waits for a reload. It does not wrap. A reload is accepted in any state. It aborts the current range, and any results still in flight from before the reload are discarded.

Top module: `key_sweep_seq`

## Requirements
- R1: After synchronous reset, `stop_need` is 1, `running` and `stop_hit` are 0, and `key_valid` is 0.
- R2: A `load_valid` pulse in any state puts the block in the running state on the next cycle, and the first key offered equals `load_key`. Results for keys accepted before or in the load cycle are discarded: they never pause the block.
- R3: After a key is accepted with no reload and no pause, the next key offered is the previous key plus one. The carry is confined to the low `LOW_W` bits, and bits `KEY_W-1:LOW_W` never change during a run.
- R4: While `key_valid` is 1 and `key_ready` is 0, `key_out` holds its value and `key_valid` stays 1.
- R5: With `key_ready` held at 1 and result latency below `DEPTH`, keys are accepted on consecutive cycles with no idle cycle, until the range ends.
- R6: A result with `result_hit`=1 for a live key while running sets `stop_hit` on the next cycle and drops `key_valid`. `hit_key` then equals the exact key whose acceptance produced that result, not the advanced counter value.
- R7: A `resume` pulse is honoured only while `stop_hit` is 1 and no results are outstanding. Offering then restarts at the low part of `hit_key` plus one. A `resume` at any other time has no effect.
- R8: Once the key with an all-ones low part has been accepted and every result has returned with no hit, `stop_need` rises and no further key is offered. If the all-ones key itself hits, a resume leads to `stop_need`.
- R9: Exactly one of `running`, `stop_hit` and `stop_need` is 1 in every cycle after reset.
- R10: Results that arrive while `stop_hit` is 1 are ignored, whatever their hit flag, and `hit_key` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_valid | input | 1 | Single-cycle write of a new starting key |
| load_key | input | KEY_W | Starting key; its upper part stays frozen for the run |
| resume | input | 1 | Host pulse that continues after a hit pause |
| key_valid | output | 1 | A candidate key is being offered |
| key_ready | input | 1 | Datapath accepts the offered key |
| key_out | output | KEY_W | Candidate key |
| result_valid | input | 1 | Datapath returns the result for the oldest accepted key |
| result_hit | input | 1 | The returned result is a candidate match |
| hit_key | output | KEY_W | Key that produced the pausing hit |
| stop_hit | output | 1 | Paused on a candidate |
| stop_need | output | 1 | Range exhausted or never loaded; waiting for a key |
| running | output | 1 | Stepping through the range |

## Verification
The checks assume that the datapath returns exactly one result per accepted key, in order. They also assume it never has more than `DEPTH` results pending and never presents a result when nothing is outstanding. The bench meets these assumptions with a fixed two-stage stub pipeline that captures each handshake and a `DEPTH` of four. The stall and step properties also assume that `load_valid` is a single-cycle pulse, and the bench drives it only that way. The hit and hold rules are exercised with ready held high, with ready held low for a while, and with ready toggled at random. Hit patterns are planted on chosen low values, including the all-ones value and values that are still in flight when a reload happens.

// File: rtl/ksq_pkg.sv
package ksq_pkg;

    typedef enum logic [1:0] {
        ST_NEED = 2'd0,
        ST_RUN  = 2'd1,
        ST_HIT  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic issue;
        logic live_pop;
        logic hit;
        logic idle;
    } step_ev_t;

    function automatic logic is_all_ones(input logic [255:0] v, input int unsigned w);
        logic r;
        r = 1'b1;
        for (int i = 0; i < 256; i++) begin
            if (i < w && !v[i]) r = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/ksq_low_ctr.sv
module ksq_low_ctr #(
    parameter int LOW_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LOW_W-1:0] load_low,
    input  logic             advance,
    input  logic             rewind,
    input  logic [LOW_W-1:0] rewind_low,
    output logic [LOW_W-1:0] low,
    output logic             all_issued
);
    localparam logic [LOW_W-1:0] LOW_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            low        <= '0;
            all_issued <= 1'b1;
        end else if (load) begin
            low        <= load_low;
            all_issued <= 1'b0;
        end else if (rewind) begin
            low        <= rewind_low + 1'b1;
            all_issued <= (rewind_low == LOW_MAX);
        end else if (advance) begin
            if (low == LOW_MAX) all_issued <= 1'b1;
            else                low        <= low + 1'b1;
        end
    end
endmodule

// File: rtl/ksq_tracker.sv
module ksq_tracker #(
    parameter int LOW_W = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [LOW_W-1:0] push_low,
    input  logic             res_valid,
    output logic [LOW_W-1:0] head_low,
    output logic             live_pop,
    output logic             full,
    output logic             idle
);
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int SKIP_W = $clog2(2 * DEPTH + 2);

    logic [LOW_W-1:0]  mem [DEPTH];
    logic [PTR_W-1:0]  wp, rp;
    logic [CNT_W-1:0]  cnt;
    logic [SKIP_W-1:0] skip;
    logic              skip_pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign skip_pop = res_valid && (skip != '0);
    assign live_pop = res_valid && (skip == '0) && (cnt != '0);
    assign full     = (cnt == CNT_W'(DEPTH));
    assign idle     = (cnt == '0) && (skip == '0);
    assign head_low = mem[rp];

    always_ff @(posedge clk) begin
        if (!rst && !flush && push) mem[wp] <= push_low;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp   <= '0;
            rp   <= '0;
            cnt  <= '0;
            skip <= '0;
        end else if (flush) begin
            wp   <= '0;
            rp   <= '0;
            cnt  <= '0;
            skip <= skip + SKIP_W'(cnt) + SKIP_W'(push) - SKIP_W'(res_valid);
        end else begin
            if (push)     wp <= ptr_inc(wp);
            if (live_pop) rp <= ptr_inc(rp);
            cnt <= cnt + CNT_W'(push) - CNT_W'(live_pop);
            if (skip_pop) skip <= skip - 1'b1;
        end
    end
endmodule

// File: rtl/ksq_ctrl.sv
module ksq_ctrl
    import ksq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       resume,
    input  logic       key_ready,
    input  logic       live_pop,
    input  logic       res_hit,
    input  logic       all_issued,
    input  logic       trk_idle,
    input  logic       trk_full,
    output seq_state_e state,
    output logic       key_valid,
    output logic       issue,
    output logic       rewind
);
    seq_state_e nxt;
    step_ev_t   ev;

    assign key_valid = (state == ST_RUN) && !all_issued && !trk_full;

    always_comb begin
        ev.issue    = key_valid && key_ready;
        ev.live_pop = live_pop;
        ev.hit      = (state == ST_RUN) && live_pop && res_hit && !load;
        ev.idle     = trk_idle;
    end

    assign issue  = ev.issue;
    assign rewind = ev.hit;

    always_comb begin
        nxt = state;
        if (load) begin
            nxt = ST_RUN;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (ev.hit)                     nxt = ST_HIT;
                    else if (all_issued && ev.idle) nxt = ST_NEED;
                end
                ST_HIT: begin
                    if (resume && ev.idle) nxt = all_issued ? ST_NEED : ST_RUN;
                end
                default: nxt = state;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_NEED;
        else     state <= nxt;
    end
endmodule

// File: rtl/key_sweep_seq.sv
module key_sweep_seq
    import ksq_pkg::*;
#(
    parameter int KEY_W = 64,
    parameter int LOW_W = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_valid,
    input  logic [KEY_W-1:0] load_key,
    input  logic             resume,
    output logic             key_valid,
    input  logic             key_ready,
    output logic [KEY_W-1:0] key_out,
    input  logic             result_valid,
    input  logic             result_hit,
    output logic [KEY_W-1:0] hit_key,
    output logic             stop_hit,
    output logic             stop_need,
    output logic             running
);
    localparam int UP_W = KEY_W - LOW_W;

    seq_state_e       state;
    logic [UP_W-1:0]  upper;
    logic [LOW_W-1:0] low, head_low, hit_low;
    logic             all_issued, issue, rewind;
    logic             live_pop, trk_full, trk_idle;

    ksq_low_ctr #(.LOW_W(LOW_W)) u_ctr (
        .clk        (clk),
        .rst        (rst),
        .load       (load_valid),
        .load_low   (load_key[LOW_W-1:0]),
        .advance    (issue),
        .rewind     (rewind),
        .rewind_low (head_low),
        .low        (low),
        .all_issued (all_issued)
    );

    ksq_tracker #(.LOW_W(LOW_W), .DEPTH(DEPTH)) u_trk (
        .clk       (clk),
        .rst       (rst),
        .flush     (load_valid),
        .push      (issue),
        .push_low  (low),
        .res_valid (result_valid),
        .head_low  (head_low),
        .live_pop  (live_pop),
        .full      (trk_full),
        .idle      (trk_idle)
    );

    ksq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .load       (load_valid),
        .resume     (resume),
        .key_ready  (key_ready),
        .live_pop   (live_pop),
        .res_hit    (result_hit),
        .all_issued (all_issued),
        .trk_idle   (trk_idle),
        .trk_full   (trk_full),
        .state      (state),
        .key_valid  (key_valid),
        .issue      (issue),
        .rewind     (rewind)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            upper   <= '0;
            hit_low <= '0;
        end else begin
            if (load_valid) upper   <= load_key[KEY_W-1:LOW_W];
            if (rewind)     hit_low <= head_low;
        end
    end

    assign key_out   = {upper, low};
    assign hit_key   = {upper, hit_low};
    assign running   = (state == ST_RUN);
    assign stop_hit  = (state == ST_HIT);
    assign stop_need = (state == ST_NEED);
endmodule

// File: rtl/ksq_checker.sv
module ksq_checker #(
    parameter int KEY_W = 64,
    parameter int LOW_W = 32,
    parameter int DEPTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             load_valid,
    input logic             key_valid,
    input logic             key_ready,
    input logic [KEY_W-1:0] key_out,
    input logic             result_valid,
    input logic [KEY_W-1:0] hit_key,
    input logic             stop_hit,
    input logic             stop_need,
    input logic             running
);
    a_r9_one_status: assert property (@(posedge clk) disable iff (rst)
        $countones({running, stop_hit, stop_need}) == 1);

    a_r2_load_runs: assert property (@(posedge clk) disable iff (rst)
        load_valid |=> running);

    a_r3_step_by_one: assert property (@(posedge clk) disable iff (rst)
        (key_valid && key_ready && !load_valid)
            |=> (!key_valid || key_out == $past(key_out) + KEY_W'(1)));

    a_r4_hold_offer: assert property (@(posedge clk) disable iff (rst)
        (key_valid && !key_ready && !load_valid && !result_valid)
            |=> (key_valid && $stable(key_out)));

    a_r6_quiet_when_stopped: assert property (@(posedge clk) disable iff (rst)
        (stop_hit || stop_need) |-> !key_valid);

    a_r10_hit_key_frozen: assert property (@(posedge clk) disable iff (rst)
        (stop_hit && !load_valid) |=> $stable(hit_key));

    a_r8_need_sticky: assert property (@(posedge clk) disable iff (rst)
        (stop_need && !load_valid) |=> stop_need);
endmodule

bind key_sweep_seq ksq_checker #(.KEY_W(KEY_W), .LOW_W(LOW_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_key_sweep_seq.sv
module tb_key_sweep_seq;
    localparam int KEY_W = 40;
    localparam int LOW_W = 4;
    localparam int DEPTH = 4;
    localparam int UP_W  = KEY_W - LOW_W;
    localparam logic [LOW_W-1:0] LMAX = '1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             load_valid = 1'b0;
    logic [KEY_W-1:0] load_key = '0;
    logic             resume = 1'b0;
    logic             key_ready = 1'b1;
    logic             key_valid, stop_hit, stop_need, running;
    logic [KEY_W-1:0] key_out, hit_key;
    logic             result_valid, result_hit;

    always #10 clk = ~clk;

    key_sweep_seq #(.KEY_W(KEY_W), .LOW_W(LOW_W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .load_valid(load_valid), .load_key(load_key),
        .resume(resume), .key_valid(key_valid), .key_ready(key_ready),
        .key_out(key_out), .result_valid(result_valid), .result_hit(result_hit),
        .hit_key(hit_key), .stop_hit(stop_hit), .stop_need(stop_need),
        .running(running)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // datapath stub: two-cycle result latency, hit on planted low values
    int plant_a = -1;
    int plant_b = -1;
    logic             p1_v = 1'b0, p2_v = 1'b0;
    logic [KEY_W-1:0] p1_k = '0, p2_k = '0;

    function automatic bit planted(input logic [KEY_W-1:0] k);
        int lv;
        lv = int'(k[LOW_W-1:0]);
        return (lv == plant_a) || (lv == plant_b);
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            p1_v <= 1'b0;
            p2_v <= 1'b0;
        end else begin
            p1_v <= key_valid && key_ready;
            p1_k <= key_out;
            p2_v <= p1_v;
            p2_k <= p1_k;
        end
    end
    assign result_valid = p2_v;
    assign result_hit   = p2_v && planted(p2_k);

    int hs_log[$];
    always @(posedge clk) if (!rst && key_valid && key_ready) hs_log.push_back(cyc);

    // behavioural reference model
    typedef struct {
        logic [LOW_W-1:0] low;
        bit               stale;
    } fl_t;

    fl_t              mq[$];
    int               m_state = 0;   // 0 need, 1 run, 2 hit
    bit               m_all = 1'b1;
    logic [LOW_W-1:0] m_next = '0;
    logic [LOW_W-1:0] m_hitlow = '0;
    logic [UP_W-1:0]  m_upper = '0;

    function automatic bit m_valid();
        int live;
        live = 0;
        foreach (mq[i]) if (!mq[i].stale) live++;
        return (m_state == 1) && !m_all && (live < DEPTH);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_all = 1'b1; m_next = '0; m_hitlow = '0; m_upper = '0;
            mq.delete();
        end else begin
            bit issue, pre_empty, hitnow;
            logic [LOW_W-1:0] hl;
            fl_t e;
            issue     = m_valid() && key_ready;
            pre_empty = (mq.size() == 0);
            hitnow    = 1'b0;
            hl        = '0;
            if (result_valid && mq.size() > 0) begin
                e = mq.pop_front();
                if (!load_valid && m_state == 1 && !e.stale && result_hit) begin
                    hitnow = 1'b1;
                    hl     = e.low;
                end
            end
            if (issue) mq.push_back('{low: m_next, stale: 1'b0});
            if (load_valid) begin
                foreach (mq[i]) mq[i].stale = 1'b1;
                m_state = 1;
                m_next  = load_key[LOW_W-1:0];
                m_upper = load_key[KEY_W-1:LOW_W];
                m_all   = 1'b0;
            end else if (m_state == 1) begin
                if (issue) begin
                    if (m_next == LMAX) m_all = 1'b1;
                    else                m_next = m_next + 1'b1;
                end
                if (hitnow) begin
                    m_state  = 2;
                    m_hitlow = hl;
                    m_all    = (hl == LMAX);
                    m_next   = hl + 1'b1;
                end else if (m_all && pre_empty && !issue) begin
                    m_state = 0;
                end
            end else if (m_state == 2) begin
                if (resume && pre_empty) m_state = m_all ? 0 : 1;
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(running == (m_state == 1), "R9 running", running, m_state == 1);
            chk(stop_hit == (m_state == 2), "R9 stop_hit", stop_hit, m_state == 2);
            chk(stop_need == (m_state == 0), "R9 stop_need", stop_need, m_state == 0);
            chk(key_valid == m_valid(), "R5 key_valid", key_valid, m_valid());
            if (m_valid())
                chk(key_out == {m_upper, m_next}, "R3 key_out", key_out, {m_upper, m_next});
            if (m_state == 2)
                chk(hit_key == {m_upper, m_hitlow}, "R6 hit_key", hit_key, {m_upper, m_hitlow});
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_load(input logic [KEY_W-1:0] k);
        load_valid = 1'b1;
        load_key   = k;
        tick();
        load_valid = 1'b0;
    endtask

    task automatic pulse_resume();
        resume = 1'b1;
        tick();
        resume = 1'b0;
    endtask

    task automatic wait_hit(input string tag, input bit rnd);
        int n;
        n = 0;
        while (!stop_hit && n < 400) begin
            if (rnd) key_ready = 1'($urandom_range(0, 1));
            tick();
            n++;
        end
        chk(stop_hit, tag, stop_hit, 1);
    endtask

    task automatic wait_need(input string tag, input bit rnd, output bit saw_hit);
        int n;
        n = 0;
        saw_hit = 1'b0;
        while (!stop_need && n < 400) begin
            if (rnd) key_ready = 1'($urandom_range(0, 1));
            if (stop_hit) saw_hit = 1'b1;
            tick();
            n++;
        end
        chk(stop_need, tag, stop_need, 1);
    endtask

    task automatic run_all();
        bit saw;
        logic [KEY_W-1:0] k0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk(stop_need && !running && !stop_hit && !key_valid, "R1 reset status",
            {stop_need, running, stop_hit, key_valid}, 4'b1000);

        // R2/R5/R8: full sweep with ready high
        key_ready = 1'b1;
        hs_log.delete();
        k0 = {36'h9_A5C3_1E07, 4'h0};
        do_load(k0);
        chk(running && key_out == k0, "R2 first key", key_out, k0);
        wait_need("R8 sweep end", 1'b0, saw);
        chk(hs_log.size() == 16, "R8 keys per range", hs_log.size(), 16);
        if (hs_log.size() == 16)
            chk(hs_log[15] - hs_log[0] == 15, "R5 back-to-back", hs_log[15] - hs_log[0], 15);
        repeat (4) tick();
        chk(stop_need && !key_valid, "R8 no wrap", key_valid, 0);

        // R4: ready held low
        key_ready = 1'b0;
        k0 = {36'h0_0F00_BEEF, 4'h3};
        do_load(k0);
        for (int i = 0; i < 3; i++) begin
            chk(key_valid && key_out == k0, "R4 hold while stalled", key_out, k0);
            tick();
        end
        key_ready = 1'b1;
        wait_need("R8 after stall", 1'b0, saw);

        // R6/R7/R10: hits at 12 and 13
        plant_a = 12;
        plant_b = 13;
        do_load({36'h3_3333_0001, 4'hA});
        wait_hit("R6 pause", 1'b0);
        chk(hit_key == {36'h3_3333_0001, 4'hC}, "R6 hit key", hit_key, {36'h3_3333_0001, 4'hC});
        chk(!key_valid, "R6 offer stops", key_valid, 0);
        pulse_resume();
        chk(stop_hit, "R7 early resume ignored", stop_hit, 1);
        repeat (5) tick();
        chk(hit_key == {36'h3_3333_0001, 4'hC}, "R10 paused result ignored", hit_key,
            {36'h3_3333_0001, 4'hC});
        pulse_resume();
        chk(running && key_out == {36'h3_3333_0001, 4'hD}, "R7 resume next key", key_out,
            {36'h3_3333_0001, 4'hD});
        wait_hit("R10 retest after resume", 1'b0);
        chk(hit_key == {36'h3_3333_0001, 4'hD}, "R10 retested hit", hit_key,
            {36'h3_3333_0001, 4'hD});
        repeat (5) tick();
        pulse_resume();
        chk(key_out == {36'h3_3333_0001, 4'hE}, "R7 second resume", key_out,
            {36'h3_3333_0001, 4'hE});
        wait_need("R8 after hits", 1'b0, saw);

        // R8: hit on the all-ones low value
        plant_a = 15;
        plant_b = -1;
        do_load({36'h7_0000_0042, 4'hE});
        wait_hit("R8 last-key hit", 1'b0);
        chk(hit_key[LOW_W-1:0] == LMAX, "R8 last-key hit value", hit_key[LOW_W-1:0], LMAX);
        repeat (5) tick();
        pulse_resume();
        chk(stop_need, "R8 resume after last key", stop_need, 1);

        // R7 resume while running; R2 abort with stale hits in flight
        plant_a = 2;
        plant_b = 3;
        do_load({36'h1_1111_1111, 4'h0});
        repeat (2) tick();
        pulse_resume();
        chk(running, "R7 resume while running ignored", running, 1);
        do_load({36'h2_2222_2222, 4'h5});
        chk(key_out == {36'h2_2222_2222, 4'h5}, "R2 reload restarts", key_out,
            {36'h2_2222_2222, 4'h5});
        wait_need("R2 reload end", 1'b0, saw);
        chk(!saw, "R2 stale results discarded", saw, 0);

        // random ready with a hit at 7
        plant_a = 7;
        plant_b = -1;
        do_load({36'h5_5AA5_0FF0, 4'h0});
        wait_hit("R6 random ready", 1'b1);
        chk(hit_key[LOW_W-1:0] == 4'h7, "R6 random ready value", hit_key[LOW_W-1:0], 4'h7);
        repeat (5) tick();
        pulse_resume();
        wait_need("R8 random ready", 1'b1, saw);
        key_ready = 1'b1;
        repeat (3) tick();
    endtask

    initial begin
        bit timed_out;
        timed_out = 1'b0;
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) chk(1'b0, "R8 watchdog expired", 0, 1);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule